// File: doc/BRIEF.md
# SPI Master with Programmable Clock Divider

This block is a register-driven SPI master. Software programs a configuration register with a 6-bit divider value `d` and two clock-mode bits, queues bytes into an 8-entry transmit FIFO, then pulses a start bit in the control register. The block drops its active-low select, shifts each queued byte out MSB first while collecting the byte returned on the serial input, and pushes every received byte into an 8-entry receive FIFO. The serial clock runs at the block clock divided by 2·(d+1), so `d` = 63 gives the slowest rate.

Each transmit word carries a flag above its eight data bits. A flagged word is the final one of the transfer. Half a serial-clock period after its last edge, the select line returns high and a sticky completion event is raised. If the transmit FIFO runs dry before a flagged word appears, the serial clock parks at its idle level with select still low, and shifting resumes once software writes more data. The event register shows transmit space, receive data and completion. Completion is cleared by writing a one to its bit.

Top module: `spi_xfer_master`

## Requirements
- R1: After reset, spiSelN is 1, spiSck is 0, the event register (address 2) reads 3'b001 and the status register (address 3) reads 0.
- R2: While select is low, consecutive serial-clock edges inside one byte are exactly d+1 clock cycles apart, where d is the configuration field at address 0 bits [5:0] (range 0..63).
- R3: Configuration bit 8 selects the capture phase and bit 9 the idle clock level. The idle spiSck level equals bit 9. With bit 8 clear, data is captured on the edge leaving idle, and with bit 8 set on the edge returning to idle. Bytes go out and come in MSB first.
- R4: A write to address 4 queues bits [7:0] as data and bit 8 as the final-word flag. The transfer ends after the flagged word, and spiSelN rises d+1 cycles after that word's last serial-clock edge.
- R5: Every byte received on spiMiso is appended to the receive FIFO. A read of address 4 returns the oldest byte and removes it, in arrival order.
- R6: Writing 1 to control bit 0 (address 1) starts a transfer only if the transmit FIFO holds data. With the FIFO empty it has no effect and spiSelN stays 1.
- R7: When the transmit FIFO empties before a flagged word, spiSck holds its idle level and spiSelN stays 0 until another word is written. Shifting then resumes.
- R8: Control bit 1 empties the receive FIFO and control bit 2 empties the transmit FIFO. All control bits read 0 once the cycle after the write has passed.
- R9: Event bit 0 is 1 while the transmit FIFO has a free entry. Event bit 1 is 1 while the receive FIFO holds data. Event bit 2 is set at the end of a transfer and stays set until a write to address 2 with bit 2 equal to 1. Writing 0 to that bit leaves it set.
- R10: Status bit 0 becomes 1 after the first write to the configuration register and stays 1.
- R11: Both FIFOs hold 8 entries. A write to a full transmit FIFO is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial clock base |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops receive FIFO at address 4) |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiSelN | output | 1 | Active-low device select |

## Verification
A wrong edge counter or phase bit shows up at the ports within one byte: the modelled peripheral sees a shifted or bit-rotated MOSI byte at its eighth capture, and the receive FIFO returns a misaligned byte on the next read. A divider fault breaks the edge spacing at the second edge of any byte. A fault in the final-word latch either releases select early, which truncates the byte stream, or keeps it low past the d+1 tail, which the select-release timing check catches in the cycle the tail should end. FIFO pointer faults show up as lost, repeated or reordered bytes on readback, and a lost drop of the ninth word shows up as a transfer that fails to stall.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_EVT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} xferState_t;

  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic pushRx;
    logic doneEv;
  } xferStrobe_t;
endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == (AW+1)'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + (AW+1)'(doPush) - (AW+1)'(doPop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full && push && !pop && !clr |=> full); // R11
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int BRG_W  = 6,
  parameter int WORD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             txEmpty,
  input  logic             txHeadLast,
  input  logic [BRG_W-1:0] brg,
  input  logic             cpha,
  output xferStrobe_t      strobe,
  output logic             selN,
  output logic             sckPhase
);
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  xferState_t        state;
  logic [BRG_W-1:0]  cnt;
  logic [EDGE_W-1:0] edgeIdx;
  logic haveWord, curLast;
  logic tick, firstEdge, preload, stallHi, edgeNow;

  assign tick      = (cnt == brg);
  assign firstEdge = (edgeIdx == '0);
  // phase 0 loads its word before the first edge, phase 1 on it
  assign preload   = (state == ST_RUN) && firstEdge && !haveWord && !cpha;
  assign stallHi   = (state == ST_RUN) && firstEdge && cpha && txEmpty;
  assign edgeNow   = (state == ST_RUN) && !preload && !stallHi && tick;

  always_comb begin
    strobe          = '0;
    strobe.loadTx   = (preload && !txEmpty) || (edgeNow && cpha && firstEdge);
    strobe.shiftTx  = edgeNow && (cpha ? (!edgeIdx[0] && !firstEdge)
                                       : (edgeIdx[0] && edgeIdx != LAST_EDGE));
    strobe.sampleRx = edgeNow && (edgeIdx[0] == cpha);
    strobe.pushRx   = edgeNow && (edgeIdx == LAST_EDGE);
    strobe.doneEv   = (state == ST_TAIL) && tick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      edgeIdx  <= '0;
      haveWord <= 1'b0;
      curLast  <= 1'b0;
      selN     <= 1'b1;
      sckPhase <= 1'b0;
    end else begin
      if (strobe.loadTx) curLast <= txHeadLast;
      unique case (state)
        ST_IDLE: if (startReq && !txEmpty) begin
          state    <= ST_RUN;
          selN     <= 1'b0;
          cnt      <= '0;
          edgeIdx  <= '0;
          haveWord <= 1'b0;
        end
        ST_RUN: begin
          if (preload) begin
            if (!txEmpty) begin
              haveWord <= 1'b1;
              cnt      <= '0;
            end
          end else if (stallHi) begin
            cnt <= '0;
          end else if (tick) begin
            cnt      <= '0;
            sckPhase <= ~sckPhase;
            edgeIdx  <= edgeIdx + 1'b1;
            if (edgeIdx == LAST_EDGE) begin
              haveWord <= 1'b0;
              if (curLast) state <= ST_TAIL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: if (tick) begin
          state <= ST_IDLE;
          selN  <= 1'b1;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_SCK_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> !sckPhase); // R3
  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && startReq && txEmpty |=> selN); // R6
  AST_STALL_FREEZES_SCK: assert property (@(posedge clk) disable iff (!rstN)
    (preload && txEmpty) || stallHi |=> $stable(sckPhase) && !selN); // R7
  AST_SEL_RELEASE_FROM_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selN) |-> $past(state) == ST_TAIL); // R4
endmodule

// File: rtl/spi_xfer_dpath.sv
module spi_xfer_dpath
  import spi_xfer_pkg::*;
#(
  parameter int BRG_W      = 6,
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  xferStrobe_t       strobe,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic              startReq,
  output logic              txEmpty,
  output logic              txHeadLast,
  output logic [BRG_W-1:0]  brg,
  output logic              cpha,
  output logic              cpol
);
  localparam int CPHA_BIT = 8;
  localparam int CPOL_BIT = 9;

  logic [2:0]        ctrlReg;
  logic              ready, doneFlag;
  logic [WORD_W-1:0] txSr, rxSr, rxNext, rxHead;
  logic [WORD_W:0]   txHead;
  logic              txFull, rxEmpty, rxFull;
  logic wrCfg, wrCtrl, wrEvt, wrData, rdData;

  assign wrCfg  = regWrEn && (regAddr == ADDR_CFG);
  assign wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
  assign wrEvt  = regWrEn && (regAddr == ADDR_EVT);
  assign wrData = regWrEn && (regAddr == ADDR_DATA);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);

  assign startReq   = ctrlReg[0];
  assign txHeadLast = txHead[WORD_W];
  assign spiMosi    = txSr[WORD_W-1];
  assign rxNext     = strobe.sampleRx ? {rxSr[WORD_W-2:0], spiMiso} : rxSr;

  spi_xfer_fifo #(.W(WORD_W+1), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(ctrlReg[2]),
    .push(wrData), .pushData(regWdata[WORD_W:0]),
    .pop(strobe.loadTx), .head(txHead), .empty(txEmpty), .full(txFull));

  spi_xfer_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(ctrlReg[1]),
    .push(strobe.pushRx), .pushData(rxNext),
    .pop(rdData), .head(rxHead), .empty(rxEmpty), .full(rxFull));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      brg      <= '0;
      cpha     <= 1'b0;
      cpol     <= 1'b0;
      ready    <= 1'b0;
      ctrlReg  <= '0;
      doneFlag <= 1'b0;
      txSr     <= '0;
      rxSr     <= '0;
    end else begin
      if (wrCfg) begin
        brg   <= regWdata[BRG_W-1:0];
        cpha  <= regWdata[CPHA_BIT];
        cpol  <= regWdata[CPOL_BIT];
        ready <= 1'b1;
      end
      ctrlReg <= wrCtrl ? regWdata[2:0] : 3'b000;
      if (strobe.doneEv)               doneFlag <= 1'b1;
      else if (wrEvt && regWdata[2])   doneFlag <= 1'b0;
      if (strobe.loadTx)       txSr <= txHead[WORD_W-1:0];
      else if (strobe.shiftTx) txSr <= {txSr[WORD_W-2:0], 1'b0};
      rxSr <= rxNext;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CFG: begin
        regRdata[BRG_W-1:0] = brg;
        regRdata[CPHA_BIT]  = cpha;
        regRdata[CPOL_BIT]  = cpol;
      end
      ADDR_CTRL: regRdata[2:0]        = ctrlReg;
      ADDR_EVT:  regRdata[2:0]        = {doneFlag, !rxEmpty, !txFull};
      ADDR_STAT: regRdata[0]          = ready;
      ADDR_DATA: regRdata[WORD_W-1:0] = rxHead;
      default:   regRdata             = '0;
    endcase
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !(wrEvt && regWdata[2]) |=> doneFlag); // R9
  AST_CTRL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtrl |=> ctrlReg == 3'b000); // R8
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready); // R10
  AST_RX_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushRx && !rxFull && !ctrlReg[1] |=> !rxEmpty); // R5
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int BRG_W      = 6,
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              spiSelN
);
  xferStrobe_t      strobe;
  logic             startReq, txEmpty, txHeadLast, cpha, cpol, sckPhase;
  logic [BRG_W-1:0] brg;

  spi_xfer_ctrl #(.BRG_W(BRG_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .txEmpty(txEmpty),
    .txHeadLast(txHeadLast), .brg(brg), .cpha(cpha), .strobe(strobe),
    .selN(spiSelN), .sckPhase(sckPhase));

  spi_xfer_dpath #(.BRG_W(BRG_W), .WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .strobe(strobe), .spiMiso(spiMiso), .spiMosi(spiMosi),
    .startReq(startReq), .txEmpty(txEmpty), .txHeadLast(txHeadLast),
    .brg(brg), .cpha(cpha), .cpol(cpol));

  assign spiSck = sckPhase ^ cpol;
endmodule

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        spiSck, spiMosi, spiSelN;
  logic        spiMiso = 1'b0;

  spi_xfer_master u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiSelN(spiSelN));

  always #2 clk = ~clk;

  int nChecks = 0, nErrors = 0, wordsDone = 0, misoIdx = 0;
  bit finished = 0;
  int bBrg = 0; bit bCpha = 0, bCpol = 0;
  logic [7:0] expMosi[$];
  logic [7:0] expRx[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWrEn = 0; regWdata = '0;
  endtask

  task automatic regRead(input logic [2:0] a, input bit popIt, output logic [15:0] d);
    @(negedge clk); regAddr = a; regRdEn = popIt; #1 d = regRdata;
    @(negedge clk); regRdEn = 0;
  endtask

  task automatic setCfg(input int brgV, input bit ph, input bit pol);
    bBrg = brgV; bCpha = ph; bCpol = pol;
    regWrite(3'd0, 16'(brgV) | (16'(ph) << 8) | (16'(pol) << 9));
  endtask

  // driver: queues a TX word and records the byte the peripheral must see
  task automatic pushTx(input logic [7:0] d, input bit last, input bit expect_it);
    regWrite(3'd4, {7'b0, last, d});
    if (expect_it) expMosi.push_back(d);
  endtask

  task automatic startXfer();
    regWrite(3'd1, 16'h0001);
  endtask

  task automatic waitDone();
    logic [15:0] v;
    v = '0;
    while (!v[2]) regRead(3'd2, 0, v);
    check(spiSelN == 1'b1, "R4 select released at done", spiSelN, 1);
    regWrite(3'd2, 16'h0004);
  endtask

  task automatic drainRx(input int n);
    logic [15:0] v;
    for (int i = 0; i < n; i++) begin
      regRead(3'd4, 1, v);
      if (expRx.size() == 0) check(0, "R5 rx unexpected byte", v, 0);
      else begin
        logic [7:0] e;
        e = expRx.pop_front();
        check(v[7:0] == e, "R5 rx byte", v[7:0], e);
      end
    end
  endtask

  // monitor / peripheral model
  bit prevSck = 0, prevSel = 1, needByte = 0;
  int cyc = 0, edgeN = 0, bitsIn = 0;
  logic [7:0] misoSr = '0, curMiso = '0, mosiSr = '0;

  function automatic logic [7:0] misoPat(input int n);
    return 8'hA5 ^ 8'(n * 37);
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (prevSel && !spiSelN) begin
        edgeN = 0; bitsIn = 0; needByte = 1; cyc = 0;
        if (!bCpha) begin
          curMiso = misoPat(misoIdx); misoIdx++; misoSr = curMiso;
          spiMiso = misoSr[7]; needByte = 0;
        end
      end
      if (!prevSel && spiSelN) begin
        check(cyc == bBrg + 1, "R4 tail length", cyc, bBrg + 1);
        check(spiSck == bCpol, "R3 idle level", spiSck, bCpol);
      end
      if (spiSck != prevSck && !spiSelN) begin
        bit leading;
        if (edgeN % 16 != 0) check(cyc == bBrg + 1, "R2 edge spacing", cyc, bBrg + 1);
        cyc = 0;
        leading = (spiSck != bCpol);
        if (leading ^ bCpha) begin
          mosiSr = {mosiSr[6:0], spiMosi};
          bitsIn++;
          if (bitsIn == 8) begin
            wordsDone++;
            expRx.push_back(curMiso);
            if (expMosi.size() == 0) check(0, "R3 mosi unexpected byte", mosiSr, 0);
            else begin
              logic [7:0] e;
              e = expMosi.pop_front();
              check(mosiSr == e, "R3 mosi byte", mosiSr, e);
            end
          end
        end else begin
          if (needByte || bitsIn == 8) begin
            curMiso = misoPat(misoIdx); misoIdx++; misoSr = curMiso;
            needByte = 0; bitsIn = 0;
          end else misoSr = {misoSr[6:0], 1'b0};
          spiMiso = misoSr[7];
        end
        edgeN++;
      end
      prevSck = spiSck; prevSel = spiSelN;
    end
  end

  task automatic runXfer(input int brgV, input bit ph, input bit pol, input int n, input int seed);
    setCfg(brgV, ph, pol);
    @(negedge clk);
    check(spiSck == pol, "R3 idle level before start", spiSck, pol);
    for (int i = 0; i < n; i++) pushTx(8'(seed * 29 + i * 71 + 3), i == n - 1, 1);
    startXfer();
    waitDone();
    check(expMosi.size() == 0, "R4 all words sent", expMosi.size(), 0);
    drainRx(n);
  endtask

  initial begin
    logic [15:0] v;
    int w0;
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    check(spiSelN == 1'b1, "R1 select idle", spiSelN, 1);
    check(spiSck == 1'b0, "R1 sck idle", spiSck, 0);
    regRead(3'd2, 0, v); check(v[2:0] == 3'b001, "R1 event reset", v[2:0], 1);
    regRead(3'd3, 0, v); check(v == 16'h0, "R1 status reset", v, 0);
    // R10 ready after configuration
    setCfg(0, 0, 0);
    regRead(3'd3, 0, v); check(v[0] == 1'b1, "R10 ready", v[0], 1);

    // first transfer with explicit event checks (R9)
    pushTx(8'h3C, 0, 1); pushTx(8'h81, 0, 1); pushTx(8'hF0, 1, 1);
    startXfer();
    v = '0;
    while (!v[2]) regRead(3'd2, 0, v);
    check(v[1] == 1'b1, "R9 rx request", v[1], 1);
    regWrite(3'd2, 16'h0003);
    regRead(3'd2, 0, v); check(v[2] == 1'b1, "R9 done kept on write 0", v[2], 1);
    regWrite(3'd2, 16'h0004);
    regRead(3'd2, 0, v); check(v[2] == 1'b0, "R9 done cleared", v[2], 0);
    drainRx(3);
    regRead(3'd2, 0, v); check(v[1] == 1'b0, "R9 rx request cleared", v[1], 0);

    // R2/R3 all four modes and several dividers
    runXfer(1, 1, 0, 2, 1);
    runXfer(2, 0, 1, 2, 2);
    runXfer(3, 1, 1, 3, 3);
    runXfer(63, 0, 0, 1, 4);
    runXfer(0, 1, 1, 4, 5);

    // R6 start with empty FIFO
    startXfer();
    repeat (30) @(negedge clk);
    check(spiSelN == 1'b1, "R6 no start when empty", spiSelN, 1);

    // R7 stall when FIFO runs dry
    setCfg(1, 1, 0);
    w0 = wordsDone;
    pushTx(8'h5A, 0, 1); pushTx(8'hC3, 0, 1);
    startXfer();
    repeat (300) @(negedge clk);
    check(spiSelN == 1'b0, "R7 select held in stall", spiSelN, 0);
    check(spiSck == 1'b0, "R7 sck parked in stall", spiSck, 0);
    check(wordsDone - w0 == 2, "R7 words before stall", wordsDone - w0, 2);
    pushTx(8'h96, 1, 1);
    waitDone();
    drainRx(3);

    // R11 full FIFO drops the ninth write
    setCfg(0, 0, 0);
    for (int i = 0; i < 8; i++) pushTx(8'(i * 17 + 1), 0, 1);
    regRead(3'd2, 0, v); check(v[0] == 1'b0, "R11 tx full", v[0], 0);
    pushTx(8'hEE, 1, 0);
    w0 = wordsDone;
    startXfer();
    repeat (400) @(negedge clk);
    check(spiSelN == 1'b0, "R11 ninth word dropped", spiSelN, 0);
    check(wordsDone - w0 == 8, "R11 eight words sent", wordsDone - w0, 8);
    drainRx(8);
    pushTx(8'h42, 1, 1);
    waitDone();
    drainRx(1);

    // R8 TX clear and self-clearing control
    pushTx(8'h11, 1, 0); pushTx(8'h22, 1, 0);
    regWrite(3'd1, 16'h0004);
    regRead(3'd1, 0, v); check(v[2:0] == 3'b000, "R8 ctrl self-clear", v[2:0], 0);
    startXfer();
    repeat (40) @(negedge clk);
    check(spiSelN == 1'b1, "R8 tx cleared", spiSelN, 1);
    // R8 RX clear
    pushTx(8'h77, 1, 1);
    startXfer();
    waitDone();
    regRead(3'd2, 0, v); check(v[1] == 1'b1, "R8 rx holds byte", v[1], 1);
    regWrite(3'd1, 16'h0002);
    expRx.delete();
    regRead(3'd2, 0, v); check(v[1] == 1'b0, "R8 rx cleared", v[1], 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule